// File: doc/BRIEF.md
# Banked Video Memory Window Mapper

This block sits between a host bus and a large linear video memory. Host accesses that land inside a fixed 64 KB window are redirected into that memory through a bank number. A bank number selects which 64 KB slice of the memory the window shows. Reads and writes each have their own bank, so a copy from one slice to another needs no bank switch in the middle. Each bank number is six bits wide. Four low bits live in a segment register and two high bits live in an extension register. Together they reach 4 MB.

Software reaches the two registers through a small 8-bit I/O port with readback. Besides the full-register writes, three alias indexes are provided:

- one sets both banks at once;
- one changes only the read bank;
- one changes only the write bank.

A build parameter removes the extension register. That base variant covers 1 MB, and a probe of the extension register does not echo the value written. The translated access leaves the block one clock after the host presents it, together with its request and direction strobes.

Top module: `vmem_bank_mapper`

## Requirements
- R1: After reset the segment register (index 0) and the extension register (index 1) both read 0x00, and an in-window access is translated with bank 0.
- R2: An access is in the window only when the host address lies in 0xA0000..0xAFFFF. For an in-window access, `mem_req` is high in the cycle after the access is presented. For any other address, `mem_req` stays low.
- R3: The translated address is bank × 0x10000 + (host address − 0xA0000). A read (`host_we`=0) uses the read bank and a write (`host_we`=1) uses the write bank.
- R4: The segment register at index 0 holds the write bank low bits in [3:0] and the read bank low bits in [7:4]. It reads back exactly what was written, for example 0x55 gives 0x55.
- R5: The extension register at index 1 holds write bank bits 5:4 in [1:0] and read bank bits 5:4 in [5:4]. Its other bits read 0, so 0x33 reads back 0x33 and 0xFF also reads back 0x33.
- R6: A write to index 2 takes a 6-bit bank from data[5:0] and sets both the read and the write bank to it in one I/O write. A read of index 2 returns the write bank.
- R7: A write to index 3 sets only the read bank from data[5:0] and leaves the write bank unchanged. A write to index 4 sets only the write bank and leaves the read bank unchanged. Reads of index 3 and index 4 return the read bank and the write bank respectively.
- R8: A host access presented in the same cycle as an I/O bank write uses the old bank. The first access presented after the I/O write's clock edge uses the new bank.
- R9: `mem_we` of a translated access equals the `host_we` of that access.
- R10: With EXT_EN=0 there is no extension register. Index 1 reads 0x00 even after 0x33 is written, and banks are limited to 0..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_we | input | 1 | I/O register write strobe |
| io_addr | input | 3 | I/O register index (0 seg, 1 ext, 2 both, 3 read bank, 4 write bank) |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O readback of the indexed register |
| host_req | input | 1 | Host access valid |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HOST_AW (20) | Host byte address |
| mem_req | output | 1 | Translated access valid (one cycle later) |
| mem_we | output | 1 | Translated access is a write |
| mem_addr | output | MEM_AW (22) | Translated video memory address |

## Verification
Reads and writes are tried with read and write banks set to different values. A swapped bank select therefore shows up as a wrong upper address field. Addresses just below, at, and just above both window edges separate a correct window compare from an off-by-one compare. The alias writes are followed by readback of the other field, which tells a true partial update from a whole-register overwrite. An access issued in the same cycle as a bank write, then one issued right after it, pins down the exact cycle in which a new bank becomes visible.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  localparam int BANK_LO_W = 4;
  localparam int BANK_HI_W = 2;
  localparam int BANK_W    = BANK_LO_W + BANK_HI_W;
  localparam int IO_DW     = 8;

  typedef enum logic [2:0] {
    IDX_SEG  = 3'd0,
    IDX_EXT  = 3'd1,
    IDX_BOTH = 3'd2,
    IDX_RD   = 3'd3,
    IDX_WR   = 3'd4
  } io_idx_e;
endpackage

// File: rtl/vbm_bank_regs.sv
module vbm_bank_regs
  import vbm_pkg::*;
#(
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [2:0]        io_addr,
  input  logic [IO_DW-1:0]  io_wdata,
  output logic [IO_DW-1:0]  io_rdata,
  output logic [BANK_W-1:0] rd_bank,
  output logic [BANK_W-1:0] wr_bank
);
  localparam logic [IO_DW-1:0] EXT_MASK = EXT_EN ? 8'h33 : 8'h00;

  logic [IO_DW-1:0] seg_q, seg_d;
  logic [IO_DW-1:0] ext_q, ext_d;
  logic             seg_en, ext_en;
  io_idx_e          idx;

  assign idx = io_idx_e'(io_addr);

  // next-state
  always_comb begin
    seg_d  = seg_q;
    ext_d  = ext_q;
    seg_en = 1'b0;
    ext_en = 1'b0;
    if (io_we) begin
      case (idx)
        IDX_SEG: begin
          seg_d  = io_wdata;
          seg_en = 1'b1;
        end
        IDX_EXT: begin
          ext_d  = io_wdata & EXT_MASK;
          ext_en = 1'b1;
        end
        IDX_BOTH: begin
          seg_d  = {io_wdata[3:0], io_wdata[3:0]};
          ext_d  = {2'b00, io_wdata[5:4], 2'b00, io_wdata[5:4]} & EXT_MASK;
          seg_en = 1'b1;
          ext_en = 1'b1;
        end
        IDX_RD: begin
          seg_d  = {io_wdata[3:0], seg_q[3:0]};
          ext_d  = {2'b00, io_wdata[5:4], ext_q[3:0]} & EXT_MASK;
          seg_en = 1'b1;
          ext_en = 1'b1;
        end
        IDX_WR: begin
          seg_d  = {seg_q[7:4], io_wdata[3:0]};
          ext_d  = {ext_q[7:2], io_wdata[5:4]} & EXT_MASK;
          seg_en = 1'b1;
          ext_en = 1'b1;
        end
        default: begin
          seg_en = 1'b0;
          ext_en = 1'b0;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seg_q <= '0;
    else if (seg_en) seg_q <= seg_d;
  end

  generate
    if (EXT_EN) begin : g_ext
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ext_q <= '0;
        else if (ext_en) ext_q <= ext_d;
      end
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = ext_en ^ (^ext_d);
      assign ext_q = '0;
    end
  endgenerate

  assign rd_bank = {ext_q[5:4], seg_q[7:4]};
  assign wr_bank = {ext_q[1:0], seg_q[3:0]};

  // readback
  always_comb begin
    case (idx)
      IDX_SEG:          io_rdata = seg_q;
      IDX_EXT:          io_rdata = ext_q;
      IDX_BOTH, IDX_WR: io_rdata = {2'b00, wr_bank};
      IDX_RD:           io_rdata = {2'b00, rd_bank};
      default:          io_rdata = '0;
    endcase
  end

  // R7
  rd_keeps_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == IDX_RD) |=> (wr_bank == $past(wr_bank)));

  // R7
  wr_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == IDX_WR) |=> (rd_bank == $past(rd_bank)));

  // R6
  both_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == IDX_BOTH) |=> (rd_bank == wr_bank));
endmodule

// File: rtl/vbm_win_decode.sv
module vbm_win_decode #(
  parameter int HOST_AW  = 20,
  parameter int WIN_AW   = 16,
  parameter int WIN_BASE = 'hA0000
) (
  input  logic [HOST_AW-1:0] host_addr,
  output logic               win_hit,
  output logic [WIN_AW-1:0]  win_off
);
  localparam int              TAG_W   = HOST_AW - WIN_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_AW);

  assign win_hit = (host_addr[HOST_AW-1:WIN_AW] == WIN_TAG);
  assign win_off = host_addr[WIN_AW-1:0];
endmodule

// File: rtl/vbm_addr_xlate.sv
module vbm_addr_xlate
  import vbm_pkg::*;
#(
  parameter int WIN_AW = 16,
  parameter int MEM_AW = WIN_AW + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic              win_hit,
  input  logic [WIN_AW-1:0] win_off,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [BANK_W-1:0] wr_bank,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr
);
  logic              take;
  logic [BANK_W-1:0] bank_sel;
  logic              req_d, we_d;
  logic [MEM_AW-1:0] addr_d;
  logic              req_q, we_q;
  logic [MEM_AW-1:0] addr_q;

  // next-state
  always_comb begin
    take     = host_req && win_hit;
    bank_sel = host_we ? wr_bank : rd_bank;
    req_d    = take;
    we_d     = host_we;
    addr_d   = MEM_AW'({bank_sel, win_off});
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
    end else if (take) begin
      we_q   <= we_d;
      addr_q <= addr_d;
    end
  end

  assign mem_req  = req_q;
  assign mem_we   = we_q;
  assign mem_addr = addr_q;

  // R2
  miss_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_req && win_hit)) |=> !mem_req);

  // R3
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && win_hit) |=> (mem_req && mem_addr[WIN_AW-1:0] == $past(win_off)));

  // R3
  read_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && win_hit && !host_we) |=> (mem_addr[MEM_AW-1:WIN_AW] == $past(rd_bank)));

  // R9
  we_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && win_hit) |=> (mem_we == $past(host_we)));
endmodule

// File: rtl/vmem_bank_mapper.sv
module vmem_bank_mapper
  import vbm_pkg::*;
#(
  parameter int HOST_AW  = 20,
  parameter int WIN_AW   = 16,
  parameter int WIN_BASE = 'hA0000,
  parameter bit EXT_EN   = 1'b1,
  parameter int MEM_AW   = WIN_AW + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_we,
  input  logic [2:0]         io_addr,
  input  logic [IO_DW-1:0]   io_wdata,
  output logic [IO_DW-1:0]   io_rdata,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MEM_AW-1:0]  mem_addr
);
  logic              rst_meta_q, rst_sync_q;
  logic [BANK_W-1:0] rd_bank, wr_bank;
  logic              win_hit;
  logic [WIN_AW-1:0] win_off;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  vbm_bank_regs #(.EXT_EN(EXT_EN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .io_we    (io_we),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .rd_bank  (rd_bank),
    .wr_bank  (wr_bank)
  );

  vbm_win_decode #(
    .HOST_AW  (HOST_AW),
    .WIN_AW   (WIN_AW),
    .WIN_BASE (WIN_BASE)
  ) u_dec (
    .host_addr (host_addr),
    .win_hit   (win_hit),
    .win_off   (win_off)
  );

  vbm_addr_xlate #(
    .WIN_AW (WIN_AW),
    .MEM_AW (MEM_AW)
  ) u_xlate (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .host_req (host_req),
    .host_we  (host_we),
    .win_hit  (win_hit),
    .win_off  (win_off),
    .rd_bank  (rd_bank),
    .wr_bank  (wr_bank),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
  );
endmodule

// File: tb/vmem_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module vmem_bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_we = 1'b0;
  logic [2:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [19:0] host_addr = '0;
  logic [7:0]  io_rdata, io_rdata_b;
  logic        mem_req, mem_we, mem_req_b, mem_we_b;
  logic [21:0] mem_addr, mem_addr_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vmem_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .host_req(host_req),
    .host_we(host_we), .host_addr(host_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr)
  );

  vmem_bank_mapper #(.EXT_EN(1'b0)) dut_base_i (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata_b), .host_req(host_req),
    .host_we(host_we), .host_addr(host_addr), .mem_req(mem_req_b),
    .mem_we(mem_we_b), .mem_addr(mem_addr_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xl(input logic [5:0] bank, input logic [19:0] a);
    return {10'd0, bank, a[15:0]};
  endfunction

  task automatic io_write(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    io_we = 1'b1; io_addr = idx; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic io_read(input logic [2:0] idx, output logic [7:0] d, output logic [7:0] db);
    @(negedge clk);
    io_addr = idx;
    #1;
    d = io_rdata;
    db = io_rdata_b;
  endtask

  task automatic access(input logic [19:0] a, input logic we);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d, db;
    io_read(3'd0, d, db); chk("R1 seg after reset", d, 8'h00);
    io_read(3'd1, d, db); chk("R1 ext after reset", d, 8'h00);
    access(20'hA1234, 1'b0);
    chk("R1 req", mem_req, 1); chk("R1 addr bank0", mem_addr, 32'h01234);
  endtask

  task automatic t_seg;
    logic [7:0] d, db;
    io_write(3'd0, 8'h55);
    io_read(3'd0, d, db); chk("R4 seg readback 0x55", d, 8'h55);
    io_write(3'd0, 8'h3A);
    io_read(3'd0, d, db); chk("R4 seg readback 0x3A", d, 8'h3A);
    access(20'hA0010, 1'b0); chk("R3 read uses read bank", mem_addr, xl(6'h03, 20'hA0010));
    access(20'hAFFFF, 1'b1); chk("R3 write uses write bank", mem_addr, xl(6'h0A, 20'hAFFFF));
  endtask

  task automatic t_ext;
    logic [7:0] d, db;
    io_write(3'd1, 8'h33);
    io_read(3'd1, d, db); chk("R5 ext 0x33 echo", d, 8'h33);
    chk("R10 base ext no echo", db, 8'h00);
    io_write(3'd1, 8'hFF);
    io_read(3'd1, d, db); chk("R5 ext unused bits zero", d, 8'h33);
    io_write(3'd0, 8'h55);
    io_write(3'd1, 8'h21);
    access(20'hA0004, 1'b0); chk("R3 read bank high bits", mem_addr, xl(6'h25, 20'hA0004));
    access(20'hA0008, 1'b1); chk("R3 write bank high bits", mem_addr, xl(6'h15, 20'hA0008));
  endtask

  task automatic t_window;
    io_write(3'd2, 8'h3F);
    access(20'h9FFFF, 1'b0); chk("R2 below window no req", mem_req, 0);
    access(20'hA0000, 1'b0); chk("R2 low edge req", mem_req, 1);
    chk("R3 low edge addr", mem_addr, xl(6'h3F, 20'hA0000));
    access(20'hAFFFF, 1'b1); chk("R2 high edge req", mem_req, 1);
    chk("R3 max addr", mem_addr, 32'h3FFFFF);
    access(20'hB0000, 1'b1); chk("R2 above window no req", mem_req, 0);
    access(20'h00000, 1'b0); chk("R2 zero address no req", mem_req, 0);
  endtask

  task automatic t_alias;
    logic [7:0] d, db;
    io_write(3'd2, 8'h2A);
    io_read(3'd0, d, db); chk("R6 both seg", d, 8'hAA);
    io_read(3'd1, d, db); chk("R6 both ext", d, 8'h22);
    io_read(3'd2, d, db); chk("R6 both readback", d, 8'h2A);
    io_write(3'd3, 8'h07);
    io_read(3'd4, d, db); chk("R7 read-only write keeps write bank", d, 8'h2A);
    io_read(3'd3, d, db); chk("R7 read bank set", d, 8'h07);
    io_write(3'd4, 8'h31);
    io_read(3'd3, d, db); chk("R7 write-only write keeps read bank", d, 8'h07);
    io_read(3'd0, d, db); chk("R7 seg after splits", d, 8'h71);
    io_read(3'd1, d, db); chk("R7 ext after splits", d, 8'h03);
    access(20'hA0100, 1'b0); chk("R7 read access bank", mem_addr, xl(6'h07, 20'hA0100));
    access(20'hA0100, 1'b1); chk("R7 write access bank", mem_addr, xl(6'h31, 20'hA0100));
  endtask

  task automatic t_timing;
    io_write(3'd2, 8'h01);
    @(negedge clk);
    io_we = 1'b1; io_addr = 3'd2; io_wdata = 8'h02;
    host_req = 1'b1; host_we = 1'b0; host_addr = 20'hA0040;
    @(negedge clk);
    io_we = 1'b0; host_req = 1'b0;
    chk("R8 same-cycle access uses old bank", mem_addr, xl(6'h01, 20'hA0040));
    access(20'hA0040, 1'b0);
    chk("R8 next access uses new bank", mem_addr, xl(6'h02, 20'hA0040));
  endtask

  task automatic t_strobe;
    access(20'hA0002, 1'b1); chk("R9 write strobe", mem_we, 1);
    access(20'hA0002, 1'b0); chk("R9 read strobe", mem_we, 0);
  endtask

  task automatic t_base;
    logic [7:0] d, db;
    io_write(3'd2, 8'h3C);
    io_read(3'd0, d, db); chk("R10 base seg", db, 8'hCC);
    io_read(3'd2, d, db); chk("R10 base bank limited", db, 8'h0C);
    access(20'hA0001, 1'b0); chk("R10 base addr", mem_addr_b, xl(6'h0C, 20'hA0001));
    chk("R10 ext variant addr", mem_addr, xl(6'h3C, 20'hA0001));
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_seg;
    t_ext;
    t_window;
    t_alias;
    t_timing;
    t_strobe;
    t_base;
    done = 1'b1;
    summary;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary;
      $finish;
    end
  end
endmodule